// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This block sits between a synchronous host and a bank of asynchronous 16-bit parallel EPROMs. The host offers a word address together with a read strobe. When the sequencer is ready it takes the request, drives the address, and selects one device by pulling its chip-enable line low. The device is chosen from the upper host address bits. All devices share a single output-enable line. The sequencer counts clock cycles so that the device's access, enable and float limits hold. It then captures the word and returns it with a one-cycle valid pulse.

All timing limits are given in picoseconds as parameters, together with the clock period. Each one is converted to a whole number of cycles, rounded up, and never fewer than one. The output-enable line is held back after chip select by the difference between the access time and the output-enable time, so the access is no longer than it has to be. After every read, the shared bus is left quiet for the float time plus a gap of extra cycles that the host chooses per request. Only after that can any device be selected again.

The state machine has four states:
- IDLE: ready for a request.
- ADDR: address and chip enable driven, output enable held high.
- READ: output enable low.
- FLOAT: all enables high, bus settling.

It has five transitions:
- IDLE→ADDR on an accepted request.
- ADDR→READ when the lead count expires.
- READ→FLOAT when the enable count expires; the data is captured on the same edge.
- FLOAT→IDLE when the float-plus-gap count expires.
- IDLE→IDLE while no request is pending.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: During and straight after reset, every chip-enable output is high, output enable is high, ready is high and valid is low.
- R2: A request is taken on a clock edge where both the read strobe and ready are high. Ready stays low from that edge until the float wait ends, including the cycle in which valid is high.
- R3: Device number d is bits [MEM_AW+DEV_W-1:MEM_AW] of the host address, and it pulls chip-enable bit d low. At most one chip-enable bit is low at any time. The memory address equals the low MEM_AW host address bits and does not change while a device is selected.
- R4: After chip enable goes low, output enable stays high for LEAD cycles. LEAD is ceil((access time − output-enable time)/clock period), with a minimum of 1.
- R5: Output enable is low for exactly OEN cycles, where OEN is ceil(output-enable time/clock period) with a minimum of 1. Output enable is never low while no device is selected. The captured word contains no unknown bits.
- R6: The data bus is sampled on the same edge where chip enable and output enable both rise. In the next cycle valid is high for exactly one cycle and carries that word.
- R7: After a read ends, no device is selected for at least FLT cycles, where FLT is ceil(float time/clock period) with a minimum of 1. Two devices never drive the bus at once.
- R8: The gap input is sampled with the request. The wait after the read is FLT plus that many cycles, and gap values from 0 to 2^GAP_W−1 are all honoured.
- R9: A request that arrives, or is held, while a read or its float wait is in progress is stalled. It is accepted on the first edge after the block returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read strobe; hold until taken |
| rd_addr | input | MEM_AW+DEV_W | Host word address; upper bits pick the device |
| rd_gap | input | GAP_W | Extra bus-turnaround cycles for this read |
| rd_ready | output | 1 | High when a request can be taken |
| rd_valid | output | 1 | One-cycle pulse with the returned word |
| rd_data | output | DATA_W | Captured word |
| mem_addr | output | MEM_AW | Address bus to the devices |
| mem_ce_n | output | NUM_DEV | Active-low chip enable, one per device |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq | input | DATA_W | Data bus from the devices |

## Verification
The bench builds the block three times, with a 5 ns clock and four devices in each build:
- The fastest grade (55/40/30 ns) gives a three-cycle lead before output enable.
- An edge build (42/40/3 ns) makes both the lead and the float wait round up to the one-cycle minimum.
- The slowest grade (250/75/50 ns) gives a long lead of 35 cycles.

In each build, a timed memory model drives unknown data until both its delays have passed. It keeps driving during the float time, which exposes any early sample or bus clash. The host stream covers the lowest and highest words, every device, gap values up to the maximum, and back-to-back requests that stall during the float wait.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ps/1ps
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_FLOAT
    } rd_state_e;

    // Whole clock cycles covering a delay, never below one.
    function automatic int unsigned to_cycles(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
`timescale 1ps/1ps
module eprom_rd_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/eprom_rd_select.sv
`timescale 1ps/1ps
module eprom_rd_select #(
    parameter int unsigned NUM_DEV = 4,
    parameter int unsigned DEV_W   = 2
) (
    input  logic [DEV_W-1:0]   dev,
    input  logic               active,
    output logic [NUM_DEV-1:0] sel_n
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
        assign sel_n[i] = !(active && (dev == DEV_W'(i)));
    end
endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ps/1ps
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int unsigned NUM_DEV   = 4,
    parameter int unsigned MEM_AW    = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned GAP_W     = 4,
    parameter int unsigned CLK_PS    = 5000,
    parameter int unsigned T_ACC_PS  = 55000,
    parameter int unsigned T_OE_PS   = 40000,
    parameter int unsigned T_DF_PS   = 30000,
    localparam int unsigned DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_req,
    input  logic [MEM_AW+DEV_W-1:0] rd_addr,
    input  logic [GAP_W-1:0]        rd_gap,
    output logic                    rd_ready,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data,
    output logic [MEM_AW-1:0]       mem_addr,
    output logic [NUM_DEV-1:0]      mem_ce_n,
    output logic                    mem_oe_n,
    input  logic [DATA_W-1:0]       mem_dq
);
    localparam int unsigned LEAD_CYC = (T_ACC_PS > T_OE_PS) ? to_cycles(T_ACC_PS - T_OE_PS, CLK_PS) : 1;
    localparam int unsigned OEN_CYC  = to_cycles(T_OE_PS, CLK_PS);
    localparam int unsigned FLT_CYC  = to_cycles(T_DF_PS, CLK_PS);
    localparam int unsigned FLT_MAX  = FLT_CYC + (2 ** GAP_W) - 1;
    localparam int unsigned MAX_CYC  = (LEAD_CYC > OEN_CYC) ?
                                       ((LEAD_CYC > FLT_MAX) ? LEAD_CYC : FLT_MAX) :
                                       ((OEN_CYC > FLT_MAX) ? OEN_CYC : FLT_MAX);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] OEN_LD  = CNT_W'(OEN_CYC - 1);

    rd_state_e         state_q, state_d;
    logic              accept, tmr_load, tmr_expired, capture, sel_active;
    logic [CNT_W-1:0]  tmr_val;
    logic [MEM_AW-1:0] addr_q;
    logic [DEV_W-1:0]  dev_q;
    logic [GAP_W-1:0]  gap_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    assign accept  = rd_req && (state_q == ST_IDLE);
    assign capture = (state_q == ST_READ) && tmr_expired;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                state_d  = ST_ADDR;
                tmr_load = 1'b1;
                tmr_val  = LEAD_LD;
            end
            ST_ADDR: if (tmr_expired) begin
                state_d  = ST_READ;
                tmr_load = 1'b1;
                tmr_val  = OEN_LD;
            end
            ST_READ: if (tmr_expired) begin
                state_d  = ST_FLOAT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(FLT_CYC - 1) + CNT_W'(gap_q);
            end
            ST_FLOAT: if (tmr_expired) begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        sel_active = 1'b0;
        mem_oe_n   = 1'b1;
        rd_ready   = 1'b0;
        unique case (state_q)
            ST_IDLE:  rd_ready   = 1'b1;
            ST_ADDR:  sel_active = 1'b1;
            ST_READ: begin
                sel_active = 1'b1;
                mem_oe_n   = 1'b0;
            end
            ST_FLOAT: ;
        endcase
    end

    // Request and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            dev_q   <= '0;
            gap_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= rd_addr[MEM_AW-1:0];
                dev_q  <= rd_addr[MEM_AW+DEV_W-1:MEM_AW];
                gap_q  <= rd_gap;
            end
            if (capture) data_q <= mem_dq;
            valid_q <= capture;
        end
    end

    eprom_rd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    eprom_rd_select #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_select (
        .dev    (dev_q),
        .active (sel_active),
        .sel_n  (mem_ce_n)
    );

    assign mem_addr = addr_q;
    assign rd_data  = data_q;
    assign rd_valid = valid_q;

    // Checking logic: window counters observed at the memory-side ports
    logic             any_sel;
    logic [CNT_W-1:0] lead_cnt, idle_cnt;
    assign any_sel = ~&mem_ce_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_cnt <= '0;
            idle_cnt <= CNT_W'(FLT_CYC);
        end else begin
            if (!any_sel)                           lead_cnt <= '0;
            else if (lead_cnt < CNT_W'(LEAD_CYC))   lead_cnt <= lead_cnt + 1'b1;
            if (any_sel)                            idle_cnt <= '0;
            else if (idle_cnt < CNT_W'(FLT_CYC))    idle_cnt <= idle_cnt + 1'b1;
        end
    end

    a_r2_busy_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !rd_ready);
    a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (any_sel && $past(any_sel)) |-> $stable(mem_addr));
    a_r4_oe_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (lead_cnt >= CNT_W'(LEAD_CYC)));
    a_r5_oe_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> any_sel);
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r6_capture_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));
    a_r7_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_sel) |-> (idle_cnt >= CNT_W'(FLT_CYC)));
endmodule

// File: tb/eprom_rd_ctrl_bench.sv
`timescale 1ps/1ps
module eprom_rd_lane #(
    parameter int unsigned T_ACC = 55000,
    parameter int unsigned T_OE  = 40000,
    parameter int unsigned T_DF  = 30000,
    parameter int          NREQ  = 12
) (
    input logic clk,
    input logic rst_n
);
    localparam int CLK = 5000;
    function automatic int cyc(input int t);
        int c;
        c = (t + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int LEAD = (T_ACC > T_OE) ? cyc(T_ACC - T_OE) : 1;
    localparam int OEN  = cyc(T_OE);
    localparam int FLT  = cyc(T_DF);

    logic        req = 1'b0;
    logic [17:0] haddr = '0;
    logic [3:0]  gap = '0;
    logic        ready, valid, oe_n;
    logic [15:0] data, maddr;
    logic [15:0] dq = 'x;
    logic [3:0]  ce_n;

    eprom_rd_ctrl #(.T_ACC_PS(T_ACC), .T_OE_PS(T_OE), .T_DF_PS(T_DF)) u_eprom_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_req(req), .rd_addr(haddr), .rd_gap(gap),
        .rd_ready(ready), .rd_valid(valid), .rd_data(data),
        .mem_addr(maddr), .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_dq(dq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    function automatic logic [15:0] word_of(input int d, input logic [15:0] a);
        return a ^ 16'(d * 16'h1111) ^ 16'hA5C3;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s (t_acc=%0d): actual %h expected %h", tag, what, T_ACC, act, exp);
        end
    endtask

    // Behavioural device bank: unknown data until both delays have passed.
    time t_sel[4];
    time t_off[4];
    time t_oe = 0;
    bit  hold[4];
    bit  clash = 1'b0;
    logic [3:0]  ce_p = 4'hF;
    logic        oe_p = 1'b1;
    logic [15:0] a_p = '0;

    initial for (int d = 0; d < 4; d++) begin t_sel[d] = 0; t_off[d] = 0; hold[d] = 0; end

    always @(ce_n or oe_n or maddr) begin
        for (int d = 0; d < 4; d++) begin
            if (ce_n[d] === 1'b0 && ce_p[d] === 1'b1) t_sel[d] = $time;
            if ((ce_p[d] === 1'b0 && oe_p === 1'b0) && !(ce_n[d] === 1'b0 && oe_n === 1'b0)) begin
                hold[d]  = 1'b1;
                t_off[d] = $time;
            end
        end
        if (maddr !== a_p) for (int d = 0; d < 4; d++) t_sel[d] = $time;
        if (oe_n === 1'b0 && oe_p === 1'b1) t_oe = $time;
        ce_p = ce_n; oe_p = oe_n; a_p = maddr;
    end

    initial begin
        forever begin
            int ndrv;
            int who;
            #100;
            ndrv = 0; who = -1;
            for (int d = 0; d < 4; d++) begin
                if (hold[d] && $time >= t_off[d] + T_DF) hold[d] = 1'b0;
                if (ce_n[d] === 1'b0 && oe_n === 1'b0) begin ndrv++; who = d; end
                else if (hold[d]) ndrv++;
            end
            if (ndrv > 1 && !clash) begin
                clash = 1'b1;
                chk(1'b0, "R7", "bus contention drivers", 32'(ndrv), 32'd1);
            end else if (ndrv <= 1) clash = 1'b0;
            if (who >= 0 && $time + 1000 >= t_sel[who] + T_ACC && $time + 1000 >= t_oe + T_OE)
                dq = word_of(who, maddr);
            else
                dq = 'x;
        end
    end

    // Reference schedule, advanced on each rising edge.
    int k = 0;
    int g_r = 0;
    int d_r = 0;
    logic [15:0] a_r = '0;

    always @(posedge clk) begin
        if (!rst_n) k = 0;
        else if (k != 0) begin
            if (k == LEAD + OEN + FLT + g_r) k = 0;
            else k++;
        end else if (req) begin
            k = 1; g_r = int'(gap); d_r = int'(haddr[17:16]); a_r = haddr[15:0];
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(ready === 1'b1, "R1", "ready in reset", 32'(ready), 32'd1);
            chk(ce_n === 4'hF, "R1", "ce_n in reset", 32'(ce_n), 32'hF);
            chk(oe_n === 1'b1, "R1", "oe_n in reset", 32'(oe_n), 32'd1);
            chk(valid === 1'b0, "R1", "valid in reset", 32'(valid), 32'd0);
        end else begin
            bit sel, oen;
            logic [3:0] exp_ce;
            sel = (k >= 1) && (k <= LEAD + OEN);
            oen = (k >= LEAD + 1) && (k <= LEAD + OEN);
            exp_ce = sel ? ~(4'b1 << d_r) : 4'hF;
            chk(ready === (k == 0), (k == 0) ? "R9" : ((k > LEAD + OEN + FLT) ? "R8" : "R2"),
                "ready", 32'(ready), 32'(k == 0));
            chk(ce_n === exp_ce, (k > LEAD + OEN) ? "R7" : "R3", "ce_n", 32'(ce_n), 32'(exp_ce));
            chk(oe_n === !oen, (k <= LEAD) ? "R4" : "R5", "oe_n", 32'(oe_n), 32'(!oen));
            if (sel) chk(maddr === a_r, "R3", "mem_addr", 32'(maddr), 32'(a_r));
            chk(valid === (k == LEAD + OEN + 1), "R6", "valid", 32'(valid), 32'(k == LEAD + OEN + 1));
            if (k == LEAD + OEN + 1) begin
                chk(!$isunknown(data), "R5", "captured word has X", 32'(data), 32'(word_of(d_r, a_r)));
                chk(data === word_of(d_r, a_r), "R6", "rd_data", 32'(data), 32'(word_of(d_r, a_r)));
            end
        end
    end

    // Host stimulus
    initial begin
        @(posedge rst_n);
        for (int i = 0; i < NREQ; i++) begin
            @(negedge clk);
            req   = 1'b1;
            haddr = {2'(i * 3), (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'(i * 16'h1357 + 5)};
            gap   = (i == 5) ? 4'hF : 4'(i % 4);
            while (!ready) @(negedge clk);
            @(posedge clk);
            if (i % 3 == 0) begin
                @(negedge clk);
                req = 1'b0;
                repeat (2) @(negedge clk);
            end
        end
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1'b1;
    end
endmodule

module eprom_rd_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2500 clk = ~clk;

    eprom_rd_lane #(.T_ACC(55000),  .T_OE(40000), .T_DF(30000)) u_lane_fast (.clk(clk), .rst_n(rst_n));
    eprom_rd_lane #(.T_ACC(42000),  .T_OE(40000), .T_DF(3000))  u_lane_min  (.clk(clk), .rst_n(rst_n));
    eprom_rd_lane #(.T_ACC(250000), .T_OE(75000), .T_DF(50000)) u_lane_slow (.clk(clk), .rst_n(rst_n));

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    end

    initial begin
        int cycles;
        int cmp;
        int bad;
        cycles = 0;
        while (!(u_lane_fast.done && u_lane_min.done && u_lane_slow.done) && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        cmp = u_lane_fast.n_cmp + u_lane_min.n_cmp + u_lane_slow.n_cmp;
        bad = u_lane_fast.n_bad + u_lane_min.n_bad + u_lane_slow.n_bad;
        if (cycles >= 100000) begin
            cmp++;
            bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
        $finish;
    end
endmodule